// File: doc/BRIEF.md
# Sequential Slice-Table Population Counter

This block counts how many bits are set in an input word. It does not use one wide adder tree. It works over several clock cycles instead. A small constant table gives the number of ones for every possible value of a narrow slice of the word. The block reads one slice per clock and adds that slice's table entry to a running total.

A caller holds the word on `din` and pulses `start` while the block is idle. The word is copied into an internal shift register on that edge. From then on, `din` is free to change. `busy` stays high while the slices are walked. `done` pulses for one cycle when the result is ready on `ones`. The result stays on `ones` until the next accepted start.

The reset is asynchronous, and a parameter chooses its active level. When the word width is not a multiple of the slice width, the top slice is padded with zeros.

Top module: `seq_slice_popcnt`

## Requirements
- R1: After a count finishes, `ones` equals the number of set bits in the `din` value captured at the accepted start.
- R2: `ones` is `$clog2(WIDTH+1)` bits wide and can show every count from 0 to WIDTH. An all-ones word gives exactly WIDTH.
- R3: A start sampled while idle makes `busy` high from the next cycle. `busy` then stays high for exactly ceil(WIDTH/SLICE_W) cycles (4 cycles with the defaults WIDTH=13, SLICE_W=4).
- R4: `done` is high for exactly one cycle: the first cycle in which `busy` is low again.
- R5: While idle and with no start, `ones` keeps its value. It holds the finished result until the next accepted start.
- R6: Changes on `din` after the start edge do not change the count in progress.
- R7: `start` has no effect while `busy` is high. The result and the length of `busy` are unchanged.
- R8: When `arst` equals RST_LEVEL (default 1), `busy`, `done` and `ones` clear at once, without waiting for a clock edge.
- R9: When WIDTH is not a multiple of SLICE_W, the missing top bits of the last slice count as zero. With the defaults, bit 12 is alone in the fourth slice and is counted correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| arst | input | 1 | Asynchronous reset, active when equal to RST_LEVEL |
| start | input | 1 | Begin a count of `din`; taken only while idle |
| busy | output | 1 | A count is in progress |
| done | output | 1 | One-cycle pulse: `ones` holds the finished count |
| din | input | WIDTH | Word whose set bits are counted |
| ones | output | $clog2(WIDTH+1) | Running total, then the final count |

## Verification
The bench runs words whose set bits sit only in the padded top slice, only in the lowest slice, and in every slice. A design that mishandles padding or slice order gets these counts wrong by a fixed amount.

It flips `din` and raises `start` in the middle of a count. A design that does not capture the word would mix old and new bits. A design that restarts on a busy start would stretch `busy` or lose the partial sum.

It starts a new count in the same cycle that `done` is high. It then holds the idle state for many cycles to catch a result that drifts.

It asserts reset between clock edges during a count. A design with a synchronous reset would leave `busy` high until the next edge.

// File: rtl/seq_slice_popcnt.sv
module seq_slice_popcnt #(
  parameter int   WIDTH     = 13,
  parameter int   SLICE_W   = 4,
  parameter logic RST_LEVEL = 1'b1,
  localparam int  CNT_W     = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             arst,
  input  logic             start,
  output logic             busy,
  output logic             done,
  input  logic [WIDTH-1:0] din,
  output logic [CNT_W-1:0] ones
);
  localparam int NSLICE = (WIDTH + SLICE_W - 1) / SLICE_W;
  localparam int PAD_W  = NSLICE * SLICE_W;
  localparam int LUT_N  = 2 ** SLICE_W;
  localparam int LUT_W  = $clog2(SLICE_W + 1);
  localparam int IDX_W  = (NSLICE > 1) ? $clog2(NSLICE) : 1;

  function automatic logic [LUT_W-1:0] bits_set(input int v);
    int n = 0;
    for (int b = 0; b < SLICE_W; b++) n += (v >> b) & 1;
    return LUT_W'(n);
  endfunction

  logic [LUT_W-1:0] lut [LUT_N];
  for (genvar g = 0; g < LUT_N; g++) begin : g_lut
    assign lut[g] = bits_set(g);
  end

  logic             rst_a;
  logic [PAD_W-1:0] shreg;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] acc;
  logic             last;

  assign rst_a = (arst == RST_LEVEL);
  assign last  = (idx == IDX_W'(NSLICE - 1));
  assign ones  = acc;

  always_ff @(posedge clk or posedge rst_a) begin
    if (rst_a) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      acc   <= '0;
      idx   <= '0;
      shreg <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          shreg <= PAD_W'(din);
          acc   <= '0;
          idx   <= '0;
          busy  <= 1'b1;
        end
      end else begin
        acc   <= acc + CNT_W'(lut[shreg[SLICE_W-1:0]]);
        shreg <= shreg >> SLICE_W;
        idx   <= idx + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/seq_slice_popcnt_chk.sv
module seq_slice_popcnt_chk #(
  parameter int   WIDTH     = 13,
  parameter int   SLICE_W   = 4,
  parameter logic RST_LEVEL = 1'b1,
  localparam int  CNT_W     = $clog2(WIDTH + 1)
) (
  input logic             clk,
  input logic             arst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] ones
);
  localparam int NSLICE = (WIDTH + SLICE_W - 1) / SLICE_W;

  logic        rst_a;
  logic [15:0] busy_len;
  assign rst_a = (arst == RST_LEVEL);

  always_ff @(posedge clk or posedge rst_a) begin
    if (rst_a)     busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst_a) ones <= CNT_W'(WIDTH)); // R2
  AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (rst_a) (start && !busy) |=> busy); // R3
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst_a) $fell(busy) |-> (busy_len == 16'(NSLICE))); // R3
  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (rst_a) $fell(busy) |-> done); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst_a) done |=> !done); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst_a) done |-> !busy); // R4
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst_a) (!busy && !start) |=> $stable(ones)); // R5
endmodule

bind seq_slice_popcnt seq_slice_popcnt_chk #(
  .WIDTH(WIDTH), .SLICE_W(SLICE_W), .RST_LEVEL(RST_LEVEL)
) u_chk (
  .clk(clk), .arst(arst), .start(start), .busy(busy), .done(done), .ones(ones)
);

// File: tb/tb_seq_slice_popcnt.sv
`timescale 1ns/1ps
module tb_seq_slice_popcnt;
  localparam int W = 13;
  localparam int CW = $clog2(W + 1);
  localparam int NV = 10;
  localparam logic [W-1:0] VIN [NV] = '{13'h0000, 13'h1FFF, 13'h1000, 13'h0001, 13'h0AAA,
                                        13'h1555, 13'h00F0, 13'h1234, 13'h0F0F, 13'h1800};
  localparam int VEXP [NV] = '{0, 13, 1, 1, 6, 7, 4, 5, 8, 2};

  logic clk = 0, arst = 1, start = 0;
  logic busy, done;
  logic [W-1:0] din = '0;
  logic [CW-1:0] ones;
  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  seq_slice_popcnt #(.WIDTH(W), .SLICE_W(4), .RST_LEVEL(1'b1)) dut (
    .clk(clk), .arst(arst), .start(start), .busy(busy),
    .done(done), .din(din), .ones(ones));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One count of val. disturb=1 changes din and pulses start mid-count (R6, R7).
  task automatic run(input logic [W-1:0] val, input int exp, input bit disturb);
    @(negedge clk); din = val; start = 1;
    @(negedge clk); start = 0;
    check(busy === 1'b1, "R3 busy after start", busy, 1);
    for (int c = 1; c < 4; c++) begin
      if (disturb) begin din = ~val; start = (c == 1); end
      @(negedge clk);
      start = 0;
      check(busy === 1'b1, "R3 busy held", busy, 1);
      if (disturb) check(busy === 1'b1, "R7 start ignored while busy", busy, 1);
    end
    @(negedge clk);
    check(busy === 1'b0, "R3 busy length", busy, 0);
    check(done === 1'b1, "R4 done on busy fall", done, 1);
    check(ones === CW'(exp), disturb ? "R6 captured word counted" : "R1 count", ones, exp);
  endtask

  initial begin
    #(20 * 100000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #5;
    check(busy === 1'b0 && done === 1'b0, "R8 reset flags", {busy, done}, 0);
    check(ones === '0, "R8 reset count", ones, 0);
    #30 arst = 0;

    for (int i = 0; i < NV; i++) begin
      run(VIN[i], VEXP[i], 1'b0);
      @(negedge clk);
      check(done === 1'b0, "R4 done single cycle", done, 0);
      check(ones === CW'(VEXP[i]), "R5 result held", ones, VEXP[i]);
    end

    run(13'h1FFF, 13, 1'b0);               // R2 full scale
    check(ones === CW'(W), "R2 all ones gives WIDTH", ones, W);
    run(13'h1000, 1, 1'b0);                // R9 padded top slice
    check(ones === 4'd1, "R9 padded slice bit", ones, 1);

    run(13'h0123, 4, 1'b1);                // R6 and R7
    @(negedge clk);
    check(ones === 4'd4, "R7 result after ignored start", ones, 4);

    // R5: long idle with din moving
    for (int c = 0; c < 20; c++) begin din = W'(c * 977); @(negedge clk); end
    check(ones === 4'd4 && busy === 1'b0, "R5 idle hold", ones, 4);

    // start in the done cycle is accepted
    run(13'h0007, 3, 1'b0);
    din = 13'h1111; start = 1;
    @(negedge clk); start = 0;
    check(busy === 1'b1, "R3 start during done", busy, 1);
    repeat (3) @(negedge clk);
    @(negedge clk);
    check(ones === 4'd4 && done === 1'b1, "R1 back-to-back count", ones, 4);

    // R8 asynchronous reset mid-count
    @(negedge clk); din = 13'h1FFF; start = 1;
    @(negedge clk); start = 0;
    @(negedge clk);
    #3 arst = 1;
    #1;
    check(busy === 1'b0 && done === 1'b0, "R8 async clear flags", {busy, done}, 0);
    check(ones === '0, "R8 async clear count", ones, 0);
    @(negedge clk); arst = 0;
    run(13'h1555, 7, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule